// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Data Store Access Port

This block sits on a processor's simple I/O bus and gives software byte access to a small nonvolatile data array, modelled here as a behavioural memory. Software loads an address register, split into a low byte and a high byte, and an 8-bit data register through bus writes. It then pulses one of two strobes. A read strobe copies the addressed byte into the data register. A write strobe stores the data register at the addressed location.

Every accepted access holds the processor through a stall output for a fixed number of cycles: four for a read and two for a write. A write also starts a self-timed programming interval. During that interval a busy flag stays high, so software can poll it before it starts the next access. The array holds 512, 1024 or 2048 bytes. Address bits above the configured size are dropped, so no access can go beyond the array.

Top module: `nvm_byte_port`

## Requirements
- R1: The array size SIZE_BYTES is 512, 1024 or 2048, and bytes are addressed linearly from 0 to SIZE_BYTES-1. Address bits at and above log2(SIZE_BYTES) are not stored. An address with those bits set therefore reaches the same byte as the address with them cleared (default 1024: address 0x7FF reaches byte 0x3FF).
- R2: The bus register select io_sel chooses the register. Value 0 is the address bits 7:0, value 1 is the address bits 15:8, value 2 is the data register, and value 3 reads 0x00 and ignores writes. Address bits 15 down to log2(SIZE_BYTES) always read zero (default: writing 0xFF at select 1 reads back 0x03).
- R3: After reset the data register reads 0x00, and cpu_stall and busy are low. The address register has no reset value.
- R4: An accepted read strobe loads the data register with the byte at the current address. The new value can be read from the cycle after the strobe.
- R5: An accepted read strobe drives cpu_stall high for exactly RD_STALL (4) consecutive cycles, starting in the cycle after the strobe.
- R6: An accepted write strobe stores the data register at the current address and drives cpu_stall high for exactly WR_STALL (2) consecutive cycles, starting in the cycle after the strobe.
- R7: An accepted write strobe drives busy high for exactly PROG_CYCLES consecutive cycles, starting in the cycle after the strobe, after which busy falls.
- R8: A read or write strobe that arrives while busy or cpu_stall is high is ignored. The array, the data register, busy and cpu_stall keep their values. Bus writes to the registers still take effect.
- R9: If the read and write strobes arrive together while the block is idle, only the write is performed. The data register is not reloaded, and the stall lasts WR_STALL cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sel | input | 2 | Register select for bus reads and writes |
| io_we | input | 1 | Bus write enable |
| io_wdata | input | 8 | Bus write data |
| io_rdata | output | 8 | Bus read data for the selected register, combinational |
| rd_go | input | 1 | Read strobe |
| wr_go | input | 1 | Write strobe |
| cpu_stall | output | 1 | Processor hold request |
| busy | output | 1 | High while a write is programming |

## Verification
The assertions check on every cycle that each accepted strobe raises the right output in the next cycle. They check that each stall run and each busy run has exactly the length its strobe calls for, that the data register stays still while strobes are locked out, and that the unused high address bits read zero. Only the bench's scenarios can show that bytes are stored and returned correctly. The same holds for address aliasing, for a write locked out during busy leaving the old byte in place, for the simultaneous-strobe priority, and for the reset values.

// File: rtl/nvm_byte_port.sv
module nvm_byte_port #(
  parameter int SIZE_BYTES  = 1024,
  parameter int PROG_CYCLES = 20,
  parameter int RD_STALL    = 4,
  parameter int WR_STALL    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] io_sel,
  input  logic       io_we,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  input  logic       rd_go,
  input  logic       wr_go,
  output logic       cpu_stall,
  output logic       busy
);
  localparam int ADDR_W = $clog2(SIZE_BYTES);
  localparam int HI_W   = ADDR_W - 8;
  localparam int ST_MAX = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
  localparam int ST_W   = $clog2(ST_MAX + 1);
  localparam int PG_W   = $clog2(PROG_CYCLES + 1);
  localparam logic [1:0] SEL_ALO = 2'd0;
  localparam logic [1:0] SEL_AHI = 2'd1;
  localparam logic [1:0] SEL_DAT = 2'd2;

  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [7:0]        mem [SIZE_BYTES];
  logic [ST_W-1:0]   stall_q;
  logic [PG_W-1:0]   prog_q;

  wire idle  = (stall_q == '0) && (prog_q == '0);
  wire wr_ok = wr_go && idle;
  wire rd_ok = rd_go && !wr_go && idle;

  assign cpu_stall = (stall_q != '0);
  assign busy      = (prog_q != '0);

  always_ff @(posedge clk) begin
    if (io_we && io_sel == SEL_ALO) addr_q[7:0] <= io_wdata;
    if (io_we && io_sel == SEL_AHI) addr_q[ADDR_W-1:8] <= io_wdata[HI_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          data_q <= '0;
    else if (rd_ok)                      data_q <= mem[addr_q];
    else if (io_we && io_sel == SEL_DAT) data_q <= io_wdata;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[addr_q] <= data_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_q <= '0;
      prog_q  <= '0;
    end else begin
      if (wr_ok)              stall_q <= ST_W'(WR_STALL);
      else if (rd_ok)         stall_q <= ST_W'(RD_STALL);
      else if (stall_q != '0) stall_q <= stall_q - 1'b1;
      if (wr_ok)              prog_q  <= PG_W'(PROG_CYCLES);
      else if (prog_q != '0)  prog_q  <= prog_q - 1'b1;
    end
  end

  always_comb begin
    case (io_sel)
      SEL_ALO: io_rdata = addr_q[7:0];
      SEL_AHI: io_rdata = {{(16 - ADDR_W){1'b0}}, addr_q[ADDR_W-1:8]};
      SEL_DAT: io_rdata = data_q;
      default: io_rdata = 8'h00;
    endcase
  end
endmodule

module nvm_byte_port_chk #(
  parameter int SIZE_BYTES  = 1024,
  parameter int PROG_CYCLES = 20,
  parameter int RD_STALL    = 4,
  parameter int WR_STALL    = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] io_sel,
  input logic       io_we,
  input logic [7:0] io_rdata,
  input logic       rd_go,
  input logic       wr_go,
  input logic       cpu_stall,
  input logic       busy,
  input logic [7:0] data_q
);
  localparam int ADDR_W = $clog2(SIZE_BYTES);
  localparam int ST_W   = 8;
  localparam int PG_W   = $clog2(PROG_CYCLES + 2);

  wire lock   = busy || cpu_stall;
  wire acc_wr = wr_go && !lock;
  wire acc_rd = rd_go && !wr_go && !lock;

  logic [ST_W-1:0] st_run, st_exp;
  logic [PG_W-1:0] pg_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_run <= '0;
      st_exp <= '0;
      pg_run <= '0;
    end else begin
      st_run <= cpu_stall ? st_run + 1'b1 : '0;
      pg_run <= busy ? pg_run + 1'b1 : '0;
      if (acc_wr)      st_exp <= ST_W'(WR_STALL);
      else if (acc_rd) st_exp <= ST_W'(RD_STALL);
    end
  end

  a_r5_read_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> cpu_stall);
  a_r6_write_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> cpu_stall);
  a_r7_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> busy);
  a_r5_stall_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_stall) |-> st_run == st_exp);
  a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> pg_run == PG_W'(PROG_CYCLES));
  a_r8_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !(io_we && io_sel == 2'd2)) |=> $stable(data_q));
  a_r2_high_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel == 2'd1 |-> (io_rdata >> (ADDR_W - 8)) == 8'h00);
endmodule

bind nvm_byte_port nvm_byte_port_chk #(
  .SIZE_BYTES(SIZE_BYTES), .PROG_CYCLES(PROG_CYCLES),
  .RD_STALL(RD_STALL), .WR_STALL(WR_STALL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_we(io_we),
  .io_rdata(io_rdata), .rd_go(rd_go), .wr_go(wr_go),
  .cpu_stall(cpu_stall), .busy(busy), .data_q(data_q)
);

// File: tb/sim_nvm_byte_port.sv
module sim_nvm_byte_port;
  localparam int CLK_PERIOD = 10;
  localparam int PROG = 20;
  localparam int RDS  = 4;
  localparam int WRS  = 2;
  localparam int NV   = 6;
  localparam logic [18:0] VEC [NV] = '{
    {11'h000, 8'h5A}, {11'h3FF, 8'hA5}, {11'h155, 8'h3C},
    {11'h2AA, 8'hC3}, {11'h0FF, 8'h01}, {11'h100, 8'hFE}
  };

  logic clk = 0, rst_n = 0, io_we = 0, rd_go = 0, wr_go = 0;
  logic [1:0] io_sel = 0;
  logic [7:0] io_wdata = 0, io_rdata;
  logic cpu_stall, busy;
  int total = 0, bad = 0;
  int st_n, bz_n;
  bit done = 0;

  nvm_byte_port #(.SIZE_BYTES(1024), .PROG_CYCLES(PROG), .RD_STALL(RDS), .WR_STALL(WRS)) u0 (
    .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_we(io_we), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .rd_go(rd_go), .wr_go(wr_go), .cpu_stall(cpu_stall), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] s, logic [7:0] v);
    io_sel = s; io_wdata = v; io_we = 1;
    @(negedge clk);
    io_we = 0;
  endtask

  task automatic rd_reg(logic [1:0] s, output logic [7:0] v);
    io_sel = s; #1; v = io_rdata;
  endtask

  task automatic set_addr(logic [10:0] a);
    bus_wr(2'd0, a[7:0]);
    bus_wr(2'd1, {5'b0, a[10:8]});
  endtask

  task automatic strobe(logic r, logic w);
    rd_go = r; wr_go = w;
    @(negedge clk);
    rd_go = 0; wr_go = 0;
  endtask

  task automatic measure();
    st_n = 0; bz_n = 0;
    while (cpu_stall || busy) begin
      if (cpu_stall) st_n++;
      if (busy) bz_n++;
      @(negedge clk);
    end
  endtask

  task automatic read_at(logic [10:0] a, output logic [7:0] v);
    set_addr(a);
    strobe(1, 0);
    rd_reg(2'd2, v);
    measure();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd_reg(2'd2, v); check("R3 data reset", v, 8'h00);
    check("R3 stall reset", cpu_stall, 0);
    check("R3 busy reset", busy, 0);

    for (int i = 0; i < NV; i++) begin
      set_addr(VEC[i][18:8]);
      bus_wr(2'd2, VEC[i][7:0]);
      strobe(0, 1);
      measure();
      check("R6 write stall length", st_n, WRS);
      check("R7 busy length", bz_n, PROG);
    end
    for (int i = 0; i < NV; i++) begin
      set_addr(VEC[i][18:8]);
      strobe(1, 0);
      rd_reg(2'd2, v);
      check("R4 read data", v, VEC[i][7:0]);
      measure();
      check("R5 read stall length", st_n, RDS);
      check("R5 read no busy", bz_n, 0);
    end

    bus_wr(2'd1, 8'hFF);
    rd_reg(2'd1, v); check("R2 high byte masked", v, 8'h03);
    bus_wr(2'd0, 8'h9E);
    rd_reg(2'd0, v); check("R2 low byte", v, 8'h9E);
    bus_wr(2'd3, 8'h55);
    rd_reg(2'd3, v); check("R2 select 3 reads zero", v, 8'h00);
    rd_reg(2'd0, v); check("R2 select 3 write ignored", v, 8'h9E);

    bus_wr(2'd1, 8'h07); bus_wr(2'd0, 8'hFF);
    strobe(1, 0);
    rd_reg(2'd2, v); check("R1 alias 7FF to 3FF", v, 8'hA5);
    measure();

    set_addr(11'h155);
    bus_wr(2'd2, 8'hC3);
    strobe(0, 1);
    bus_wr(2'd2, 8'h11);
    strobe(0, 1);
    strobe(1, 0);
    @(negedge clk);
    rd_reg(2'd2, v); check("R8 data kept while busy", v, 8'h11);
    check("R8 no stall from locked strobe", cpu_stall, 0);
    check("R8 still busy", busy, 1);
    measure();
    read_at(11'h155, v); check("R8 locked write ignored", v, 8'hC3);

    set_addr(11'h0FF);
    bus_wr(2'd2, 8'h77);
    strobe(1, 1);
    rd_reg(2'd2, v); check("R9 data not reloaded", v, 8'h77);
    measure();
    check("R9 stall is write length", st_n, WRS);
    check("R9 busy started", bz_n, PROG);
    read_at(11'h0FF, v); check("R9 write performed", v, 8'h77);
    read_at(11'h000, v); check("R1 lowest byte", v, 8'h5A);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule